// File: doc/BRIEF.md
# Packet CRC Verdict and Interrupt Flag Unit

This unit sits behind a packet receiver's CRC engine. It reaches a verdict at the close of every accepted packet. A passing check leaves the payload in the receive FIFO and raises the CRC-good and data-ready interrupts together with a sticky CRC status bit. A failing check normally throws the payload away with a one-cycle flush pulse to the FIFO and raises nothing. A configuration override can keep the failed payload and still announce it as ready. With checking disabled, every packet is announced as ready and the CRC-related flags are left alone. An address-match pulse from the filter stage also raises the data-ready line.

The flags are levels that the host services through the FIFO. How they clear depends on the operating mode. In receive mode, draining the last FIFO byte wipes every flag. In standby, the same read only wipes the address and data-ready flags. The CRC-good interrupt and the status bit then survive until the radio is back in receive mode and a new start pattern arrives.

Top module: `crcirq_top`

## Requirements
- R1: While reset is held and until the first event after it, fifo_flush_o, irq0_o, irq1_o and crc_stat_o are all 0.
- R2: A packet end with checking enabled and a good CRC drives irq0_o, irq1_o and crc_stat_o to 1 in the cycle after the pulse, with no flush.
- R3: A packet end with checking enabled, a bad CRC and the keep override at 0 drives fifo_flush_o high for exactly the cycle after the pulse. It leaves all three flag outputs as they were.
- R4: A packet end with checking enabled, a bad CRC and the keep override at 1 sets irq0_o, leaves irq1_o and crc_stat_o unchanged, and produces no flush.
- R5: A packet end with checking disabled sets irq0_o whatever crc_good_i says. It never raises irq1_o or crc_stat_o and never flushes.
- R6: An address-match pulse sets irq0_o in the following cycle.
- R7: A last-byte read with rx_mode_i=1 clears irq0_o, irq1_o and crc_stat_o.
- R8: A last-byte read with rx_mode_i=0 (standby) clears irq0_o but leaves irq1_o and crc_stat_o unchanged.
- R9: A start-pattern pulse with rx_mode_i=1 clears irq1_o and crc_stat_o and leaves irq0_o alone. With rx_mode_i=0 it has no effect.
- R10: With no event input active, every flag output keeps its value.
- R11: When a set condition and a clear condition hit the same flag in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pkt_end_i | input | 1 | Pulse: accepted packet finished, verdict inputs valid |
| crc_good_i | input | 1 | CRC engine result for the finished packet |
| crc_en_i | input | 1 | Configuration: CRC checking enabled |
| crc_keep_i | input | 1 | Configuration: keep a failed payload and still flag it ready |
| addr_hit_i | input | 1 | Pulse: node address comparison succeeded |
| rx_mode_i | input | 1 | 1 = receive mode, 0 = standby |
| start_det_i | input | 1 | Pulse: start pattern detected |
| last_rd_i | input | 1 | Pulse: host read the last FIFO byte |
| fifo_flush_o | output | 1 | One-cycle pulse that empties the FIFO |
| irq0_o | output | 1 | Data-ready / address-match interrupt level |
| irq1_o | output | 1 | CRC-good interrupt level |
| crc_stat_o | output | 1 | Sticky CRC-passed status bit |

## Verification
The bench sweeps all 256 combinations of the eight event and configuration inputs, starting from several flag states, and compares every output against an arithmetic model of the rules. It then drives directed sequences through the corner cases. One case is a failed packet arriving while flags are already set: a unit that cleared the flags on failure would lose the previous packet's interrupt. Another is a standby drain of the last byte: a unit that ignored the mode would drop the CRC-good level the host still expects. A start pattern seen in standby must change nothing. A set and a clear landing in the same cycle must leave the flag set, since clear-priority would swallow a fresh packet's interrupt. With checking disabled and crc_good_i at 1, a unit that failed to gate the CRC result would wrongly raise irq1_o.

// File: rtl/crcirq_pkg.sv
package crcirq_pkg;

  localparam int unsigned NUM_FLAGS = 4;

  typedef enum logic [1:0] {
    FL_ADDR  = 2'd0,
    FL_DRDY  = 2'd1,
    FL_CRCOK = 2'd2,
    FL_STAT  = 2'd3
  } flag_idx_e;

  typedef struct packed {
    logic pass;
    logic fail_keep;
    logic fail_drop;
    logic bypass;
  } verdict_t;

endpackage

// File: rtl/crcirq_rst_sync.sv
module crcirq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/crcirq_verdict.sv
module crcirq_verdict
  import crcirq_pkg::*;
(
  input  logic     pkt_end,
  input  logic     crc_en,
  input  logic     crc_good,
  input  logic     keep_on_fail,
  output verdict_t verdict
);

  always_comb begin
    verdict           = '0;
    verdict.pass      = pkt_end &  crc_en &  crc_good;
    verdict.fail_keep = pkt_end &  crc_en & ~crc_good &  keep_on_fail;
    verdict.fail_drop = pkt_end &  crc_en & ~crc_good & ~keep_on_fail;
    verdict.bypass    = pkt_end & ~crc_en;
  end

endmodule

// File: rtl/crcirq_flag.sv
module crcirq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);

  logic flag_q;
  logic flag_d;
  logic flag_en;

  always_comb begin
    flag_en = set_i | clr_i;
    if (set_i) begin
      flag_d = 1'b1;
    end else begin
      flag_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (flag_en) begin
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;

endmodule

// File: rtl/crcirq_flush.sv
module crcirq_flush (
  input  logic clk,
  input  logic rst_n,
  input  logic drop_i,
  output logic flush_o
);

  logic pulse_q;
  logic pulse_d;

  always_comb begin
    pulse_d = drop_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= pulse_d;
    end
  end

  assign flush_o = pulse_q;

endmodule

// File: rtl/crcirq_top.sv
module crcirq_top
  import crcirq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pkt_end_i,
  input  logic crc_good_i,
  input  logic crc_en_i,
  input  logic crc_keep_i,
  input  logic addr_hit_i,
  input  logic rx_mode_i,
  input  logic start_det_i,
  input  logic last_rd_i,
  output logic fifo_flush_o,
  output logic irq0_o,
  output logic irq1_o,
  output logic crc_stat_o
);

  logic                 rst_sync_n;
  verdict_t             verdict;
  logic [NUM_FLAGS-1:0] flag_set;
  logic [NUM_FLAGS-1:0] flag_clr;
  logic [NUM_FLAGS-1:0] flag_q;
  logic                 rx_wipe;

  crcirq_rst_sync #(
    .STAGES(SYNC_STAGES)
  ) i_rst_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  crcirq_verdict i_verdict (
    .pkt_end     (pkt_end_i),
    .crc_en      (crc_en_i),
    .crc_good    (crc_good_i),
    .keep_on_fail(crc_keep_i),
    .verdict     (verdict)
  );

  // Route verdicts and host events onto per-flag set/clear lines.
  always_comb begin
    rx_wipe            = rx_mode_i & (last_rd_i | start_det_i);
    flag_set           = '0;
    flag_clr           = '0;
    flag_set[FL_ADDR]  = addr_hit_i;
    flag_set[FL_DRDY]  = verdict.pass | verdict.fail_keep | verdict.bypass;
    flag_set[FL_CRCOK] = verdict.pass;
    flag_set[FL_STAT]  = verdict.pass;
    flag_clr[FL_ADDR]  = last_rd_i;
    flag_clr[FL_DRDY]  = last_rd_i;
    flag_clr[FL_CRCOK] = rx_wipe;
    flag_clr[FL_STAT]  = rx_wipe;
  end

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    crcirq_flag i_flag (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .set_i (flag_set[g]),
      .clr_i (flag_clr[g]),
      .flag_o(flag_q[g])
    );
  end

  crcirq_flush i_flush (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .drop_i (verdict.fail_drop),
    .flush_o(fifo_flush_o)
  );

  assign irq0_o     = flag_q[FL_DRDY] | flag_q[FL_ADDR];
  assign irq1_o     = flag_q[FL_CRCOK];
  assign crc_stat_o = flag_q[FL_STAT];

endmodule

// File: rtl/crcirq_checker.sv
module crcirq_checker (
  input logic clk,
  input logic rst_n,
  input logic pkt_end_i,
  input logic crc_good_i,
  input logic crc_en_i,
  input logic crc_keep_i,
  input logic addr_hit_i,
  input logic rx_mode_i,
  input logic start_det_i,
  input logic last_rd_i,
  input logic fifo_flush_o,
  input logic irq0_o,
  input logic irq1_o,
  input logic crc_stat_o
);

  p_pass_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_end_i && crc_en_i && crc_good_i) |=> (irq0_o && irq1_o && crc_stat_o && !fifo_flush_o));

  p_drop_flush_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_end_i && crc_en_i && !crc_good_i && !crc_keep_i) |=> fifo_flush_o);

  p_flush_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_flush_o |-> $past(pkt_end_i && crc_en_i && !crc_good_i && !crc_keep_i));

  p_keep_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_end_i && crc_en_i && !crc_good_i && crc_keep_i) |=> (irq0_o && !fifo_flush_o));

  p_bypass_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_end_i && !crc_en_i) |=> (irq0_o && !fifo_flush_o));

  p_irq1_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq1_o) |-> $past(pkt_end_i && crc_en_i && crc_good_i));

  p_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    addr_hit_i |=> irq0_o);

  p_rx_drain_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_mode_i && last_rd_i && !pkt_end_i && !addr_hit_i) |=> (!irq0_o && !irq1_o && !crc_stat_o));

  p_stby_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_mode_i && !pkt_end_i) |=> ($stable(irq1_o) && $stable(crc_stat_o)));

  p_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_mode_i && start_det_i && !pkt_end_i) |=> (!irq1_o && !crc_stat_o));

  p_level_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!pkt_end_i && !addr_hit_i && !last_rd_i && !start_det_i)
      |=> ($stable(irq0_o) && $stable(irq1_o) && $stable(crc_stat_o)));

  p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_end_i && crc_en_i && crc_good_i && rx_mode_i && last_rd_i) |=> (irq1_o && crc_stat_o));

endmodule

bind crcirq_top crcirq_checker i_checker (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .pkt_end_i   (pkt_end_i),
  .crc_good_i  (crc_good_i),
  .crc_en_i    (crc_en_i),
  .crc_keep_i  (crc_keep_i),
  .addr_hit_i  (addr_hit_i),
  .rx_mode_i   (rx_mode_i),
  .start_det_i (start_det_i),
  .last_rd_i   (last_rd_i),
  .fifo_flush_o(fifo_flush_o),
  .irq0_o      (irq0_o),
  .irq1_o      (irq1_o),
  .crc_stat_o  (crc_stat_o)
);

// File: tb/test_crcirq_top.sv
`timescale 1ns/1ps
module test_crcirq_top;

  localparam int unsigned SYNC_STAGES = 2;
  localparam int unsigned B_PE = 7, B_EN = 6, B_GD = 5, B_KP = 4,
                          B_AH = 3, B_RX = 2, B_ST = 1, B_LR = 0;

  logic clk;
  logic rst_n;
  logic pkt_end_i, crc_good_i, crc_en_i, crc_keep_i;
  logic addr_hit_i, rx_mode_i, start_det_i, last_rd_i;
  logic fifo_flush_o, irq0_o, irq1_o, crc_stat_o;

  int n_checks;
  int n_fails;

  // Reference state
  logic m_addr, m_drdy, m_ok, m_stat, m_flush;

  crcirq_top #(.SYNC_STAGES(SYNC_STAGES)) i_crcirq_top (
    .clk         (clk),
    .rst_n       (rst_n),
    .pkt_end_i   (pkt_end_i),
    .crc_good_i  (crc_good_i),
    .crc_en_i    (crc_en_i),
    .crc_keep_i  (crc_keep_i),
    .addr_hit_i  (addr_hit_i),
    .rx_mode_i   (rx_mode_i),
    .start_det_i (start_det_i),
    .last_rd_i   (last_rd_i),
    .fifo_flush_o(fifo_flush_o),
    .irq0_o      (irq0_o),
    .irq1_o      (irq1_o),
    .crc_stat_o  (crc_stat_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  task automatic drive(input logic [7:0] v);
    pkt_end_i   = v[B_PE];
    crc_en_i    = v[B_EN];
    crc_good_i  = v[B_GD];
    crc_keep_i  = v[B_KP];
    addr_hit_i  = v[B_AH];
    rx_mode_i   = v[B_RX];
    start_det_i = v[B_ST];
    last_rd_i   = v[B_LR];
  endtask

  // Apply one cycle of inputs, advance the model, check at the next falling edge.
  task automatic step(input logic [7:0] v, input string tag);
    logic pass, keep, drop, byp, wipe;
    drive(v);
    @(posedge clk);
    pass = v[B_PE] &  v[B_EN] &  v[B_GD];
    keep = v[B_PE] &  v[B_EN] & ~v[B_GD] &  v[B_KP];
    drop = v[B_PE] &  v[B_EN] & ~v[B_GD] & ~v[B_KP];
    byp  = v[B_PE] & ~v[B_EN];
    wipe = v[B_RX] & (v[B_LR] | v[B_ST]);
    m_addr  = v[B_AH] ? 1'b1 : (v[B_LR] ? 1'b0 : m_addr);
    m_drdy  = (pass | keep | byp) ? 1'b1 : (v[B_LR] ? 1'b0 : m_drdy);
    m_ok    = pass ? 1'b1 : (wipe ? 1'b0 : m_ok);
    m_stat  = pass ? 1'b1 : (wipe ? 1'b0 : m_stat);
    m_flush = drop;
    @(negedge clk);
    chk(tag, "fifo_flush_o", fifo_flush_o, m_flush);
    chk(tag, "irq0_o", irq0_o, m_addr | m_drdy);
    chk(tag, "irq1_o", irq1_o, m_ok);
    chk(tag, "crc_stat_o", crc_stat_o, m_stat);
  endtask

  localparam logic [7:0] V_IDLE   = 8'h00;
  localparam logic [7:0] V_PASS   = 8'b1110_0100;
  localparam logic [7:0] V_DROP   = 8'b1100_0100;
  localparam logic [7:0] V_KEEP   = 8'b1101_0100;
  localparam logic [7:0] V_BYPASS = 8'b1010_0100;
  localparam logic [7:0] V_ADDR   = 8'b0000_1100;
  localparam logic [7:0] V_RXRD   = 8'b0000_0101;
  localparam logic [7:0] V_SBRD   = 8'b0000_0001;
  localparam logic [7:0] V_SBST   = 8'b0000_0010;
  localparam logic [7:0] V_RXST   = 8'b0000_0110;

  initial begin
    n_checks = 0;
    n_fails  = 0;
    m_addr = 1'b0; m_drdy = 1'b0; m_ok = 1'b0; m_stat = 1'b0; m_flush = 1'b0;
    rst_n = 1'b0;
    drive(V_IDLE);
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "fifo_flush_o", fifo_flush_o, 1'b0);
    chk("R1", "irq0_o", irq0_o, 1'b0);
    chk("R1", "irq1_o", irq1_o, 1'b0);
    chk("R1", "crc_stat_o", crc_stat_o, 1'b0);
    rst_n = 1'b1;
    repeat (SYNC_STAGES + 2) @(negedge clk);
    step(V_IDLE, "R1");

    // Directed corner cases
    step(V_ADDR, "R6");
    step(V_IDLE, "R10");
    step(V_IDLE, "R10");
    step(V_RXRD, "R7");
    step(V_PASS, "R2");
    step(V_IDLE, "R10");
    step(V_DROP, "R3");         // flags already set must survive
    step(V_RXRD, "R7");
    step(V_DROP, "R3");         // no interrupt on silent drop
    step(V_IDLE, "R3");         // pulse lasts one cycle
    step(V_KEEP, "R4");
    step(V_RXRD, "R7");
    step(V_BYPASS, "R5");       // good flag high but checking disabled
    step(V_BYPASS & ~8'b0010_0000, "R5");
    step(V_RXRD, "R7");
    step(V_PASS, "R2");
    step(V_SBRD, "R8");
    step(V_SBST, "R9");         // ignored in standby
    step(V_IDLE, "R10");
    step(V_RXST, "R9");
    step(V_PASS, "R2");
    step(V_ADDR, "R6");
    step(V_RXST, "R9");         // irq0 stays
    step(V_PASS | 8'b0000_0001, "R11");
    step(V_ADDR | 8'b0000_0001, "R11");
    step(V_KEEP | 8'b0000_0011, "R11");

    // Exhaustive sweep of input vectors from evolving flag states
    for (int p = 0; p < 4; p++) begin
      for (int v = 0; v < 256; v++) begin
        logic [7:0] vec;
        vec = 8'(v) ^ 8'(p * 8'h5A);
        step(vec, vec[B_PE] ? "R3" : "R7");
        if ((v % 5) == 0) step(V_PASS, "R2");
      end
    end

    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end

  initial begin
    #(20 * 100000);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end

endmodule